// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low reset pushbutton, or any slow active-low reset pin, is held low. Firmware can then tell a long press, used to request a factory reset, from a short one. The block runs from a 25 MHz reference clock. At that rate each count is 40 ns and 25,000,000 counts make one second. Software compares the count against its own threshold in seconds. The threshold and the action taken on a long press are not part of the block.

The pin is asynchronous. A two-stage synchroniser brings it into the reference clock domain. While the synchronised pin is low, the counter advances by one each cycle. When the pin returns high the counter stops and keeps its value. A later press, with no clear in between, adds to the held value. At full scale (29 bits by default, about 21.4 s) the counter stops and stays there. Software reads the count through a 32-bit read port. It clears the counter by writing a word with bit 31 set.

Top module: `rst_hold_timer`

## Requirements
- R1: While the synchronised pin is low, the count rises by exactly one per reference clock cycle.
- R2: The pin passes through two flops before it reaches the counter. If the pin is first sampled low at rising edge k, the count first changes at edge k+2. The total added by one press equals the number of rising edges at which the pin was sampled low.
- R3: Counting stops at 2^CNT_W-1 (0x1FFFFFFF at the default width of 29), and the counter holds that value while the pin stays low.
- R4: While the synchronised pin is high, the count does not change.
- R5: A new press with no clear since the last one continues counting from the held value.
- R6: A write with bit 31 of the write data at 1 sets the count to zero at the clock edge that samples the write.
- R7: A write with bit 31 at 0 leaves the count unchanged, whatever the other bits hold.
- R8: When a clear write and a counting cycle fall on the same edge, the clear wins and the count becomes zero.
- R9: The read word carries the count in bits CNT_W-1:0 (28:0 by default). Every higher bit reads as zero, including bits 30:29 and bit 31.
- R10: After reset the read word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| hold_pin_n | input | 1 | Asynchronous active-low pin whose low time is measured |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 32 | Write data; bit 31 at 1 requests a clear |
| rd_data | output | 32 | Read word: count in the low CNT_W bits, zeros above |

## Verification
Every internal error in this block shows up on rd_data, in the cycle after the faulty edge. A synchroniser of the wrong depth shifts the first increment by one edge but keeps each press's total, so the bench checks the count edge by edge at the start of a press. A wrong count step, a wrapped saturation or a lost clear priority changes the value that is read back after release. The bench checks that value against a model that adds the length of each press and saturates.

// File: rtl/rhd_pkg.sv
package rhd_pkg;
  localparam int REG_W   = 32;
  localparam int CLR_BIT = 31;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_PARK  = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/rhd_sync.sv
module rhd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rhd_count.sv
module rhd_count
  import rhd_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_low,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             at_max,
  output cnt_act_e         act
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  function automatic cnt_act_e pick_act(input logic c, input logic low, input logic full);
    if (c)         return ACT_CLEAR;
    else if (!low) return ACT_HOLD;
    else if (full) return ACT_PARK;
    else           return ACT_STEP;
  endfunction

  function automatic logic [CNT_W-1:0] next_val(input cnt_act_e a, input logic [CNT_W-1:0] cur);
    case (a)
      ACT_CLEAR: return '0;
      ACT_STEP:  return cur + 1'b1;
      default:   return cur;
    endcase
  endfunction

  assign at_max = (count == FULL);
  assign act    = pick_act(clr, pin_low, at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_val(act, count);
  end

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && pin_low && !clr) |=> (count == FULL));
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_low && !clr) |=> $stable(count));
  // R1
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_low && !clr && !at_max) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/rhd_regif.sv
module rhd_regif
  import rhd_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [CNT_W-1:0] count,
  output logic             clr,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAD_W = REG_W - CNT_W;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[CLR_BIT-1:0];

  assign clr     = wr_en & wr_data[CLR_BIT];
  assign rd_data = {{PAD_W{1'b0}}, count};

  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:CNT_W] == '0);
  // R7
  no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CLR_BIT]) |-> !clr);
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
  import rhd_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hold_pin_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  logic             pin_sync_n;
  logic             pin_low;
  logic             clr;
  logic [CNT_W-1:0] count;
  logic             at_max;
  cnt_act_e         act;

  rhd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_in(hold_pin_n), .sync_out(pin_sync_n)
  );

  assign pin_low = ~pin_sync_n;

  rhd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk_ref), .rst_n(rst_n), .pin_low(pin_low), .clr(clr),
    .count(count), .at_max(at_max), .act(act)
  );

  rhd_regif #(.CNT_W(CNT_W)) u_regif (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .clr(clr), .rd_data(rd_data)
  );

  // R8
  clr_wins_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clr && pin_low) |-> (act == ACT_CLEAR));
  // R3
  no_wrap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (at_max && !clr) |=> at_max);
endmodule

// File: tb/test_rst_hold_timer.sv
module test_rst_hold_timer;
  localparam int CLK_PERIOD = 40;
  localparam int CNT_W      = 10;
  localparam int MAXV       = (1 << CNT_W) - 1;

  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_pin_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  rst_hold_timer #(.CNT_W(CNT_W)) i_rst_hold_timer (
    .clk_ref(clk_ref), .rst_n(rst_n), .hold_pin_n(hold_pin_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int sat_add(input int base, input int n);
    return (base + n > MAXV) ? MAXV : base + n;
  endfunction

  function automatic logic [31:0] fmt_word(input int c);
    return 32'(c) & 32'(MAXV);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  // pin sampled low at n edges; read back after sync drains
  task automatic press(input int n, input string req);
    hold_pin_n = 1'b0;
    settle(n);
    hold_pin_n = 1'b1;
    settle(4);
    exp_cnt = sat_add(exp_cnt, n);
    check(req, rd_data, fmt_word(exp_cnt));
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk_ref);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    settle(3);
    check("R10 reset", rd_data, 32'h0);
    rst_n = 1'b1;
    settle(2);
    check("R10 after release", rd_data, 32'h0);

    // R2 edge-by-edge latency
    hold_pin_n = 1'b0;
    settle(1);
    check("R2 edge0", rd_data, 32'd0);
    settle(1);
    check("R2 edge1", rd_data, 32'd0);
    settle(1);
    check("R2 edge2", rd_data, 32'd1);
    settle(1);
    check("R1 edge3", rd_data, 32'd2);
    settle(3);
    hold_pin_n = 1'b1;
    settle(4);
    exp_cnt = 7;
    check("R2 total", rd_data, fmt_word(exp_cnt));
    settle(10);
    check("R4 frozen", rd_data, fmt_word(exp_cnt));

    press(5, "R5 resume");
    press(1, "R2 single edge");

    // R7 write without bit 31
    for (int k = 0; k < 4; k++) begin
      write_word({1'b0, 31'($urandom)});
      check("R7 no clear", rd_data, fmt_word(exp_cnt));
    end

    // R6 clear
    write_word(32'h8000_0000 | 32'($urandom));
    check("R6 clear", rd_data, 32'h0);
    exp_cnt = 0;

    // random presses
    for (int k = 0; k < 20; k++) begin
      press(1 + int'($urandom_range(0, 40)), "R1 random press");
      settle(int'($urandom_range(0, 6)));
      if ($urandom_range(0, 3) == 0) begin
        write_word(32'h8000_0000);
        exp_cnt = 0;
        check("R6 random clear", rd_data, 32'h0);
      end
    end

    // R8 clear on a counting edge
    write_word(32'h8000_0000);
    begin
      int len;
      int cpos;
      len = 30;
      cpos = 12;
      hold_pin_n = 1'b0;
      for (int i = 0; i < len; i++) begin
        if (i == cpos + 1) check("R8 clear wins", rd_data, 32'h0);
        if (i == cpos) begin wr_en = 1'b1; wr_data = 32'h8000_0000; end
        @(negedge clk_ref);
        wr_en = 1'b0; wr_data = '0;
      end
      hold_pin_n = 1'b1;
      settle(4);
      exp_cnt = len + 1 - cpos;
      check("R8 count after clear", rd_data, fmt_word(exp_cnt));
    end

    // R3 saturation
    press(MAXV + 60, "R3 saturate");
    check("R9 upper zero", rd_data & ~32'(MAXV), 32'h0);
    press(8, "R3 stays full");
    write_word(32'h8000_0000);
    exp_cnt = 0;
    check("R6 clear from full", rd_data, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule